// File: doc/BRIEF.md
# Configuration Load Sequencer

This block is the device-side controller that governs loading a configuration bitstream. At the end of power-on reset it samples the mode-select pins once. If they name the JTAG mode, the sequencer stays parked in its startup state. Otherwise it moves to idle and waits for the host to start a load. The host does this by driving the active-low request pin from low to high. The sequencer answers by raising its active-low status line. It then accepts bitstream beats over a valid/ready stream whose final beat carries a last marker. The block counts those beats but does not store their payload.

A successful load raises load-done. A fixed initialization phase follows, after which init-done rises and the device is in user mode. A load that fails is reported by a single low pulse on status, after which status stays high. The host acknowledges the failure by pulling the request low, and status then falls and the block is back in idle. While in user mode, a fresh low-to-high request starts a clean phase. The clean phase clears both done flags immediately and drops status when it ends.

A rising edge on the JTAG start pin begins a load from any state once power-on is over, and it abandons whatever was configured before. A falling edge on the request pin cancels a JTAG load that is in progress. Every pin-level input passes through a two-stage synchronizer. Edges are detected on the synchronized copies.

Stream rules: a beat transfers in exactly the cycles where `s_valid_i` and `s_ready_o` are both high. The source may hold `s_valid_i` high for as long as it likes. `s_ready_o` depends only on the sequencer state and never on `s_valid_i`. Outside a load, ready is low and offered beats wait.

Top module: `cfg_seq_top`

## Requirements
- R1: While reset is held, and right after it is released with mode-select not equal to 3'b111, status, load-done, init-done and ready are all low.
- R2: In idle, a load starts only on a low-to-high transition of `cfg_req_n_i`. Status then rises and ready goes high. A request held constantly high or low leaves status low.
- R3: A beat transfers only when valid and ready are both high. Ready is high only while loading, and status is then high. Beats offered while ready is low are not counted.
- R4: Load-done rises only after a beat carrying last has arrived, with at least EXP_WORDS (default 8) beats counted in total including the last one.
- R5: After load-done rises, init-done rises exactly INIT_CYC (default 8) cycles later. Init-done is never high while load-done is low.
- R6: A last beat that arrives with fewer than EXP_WORDS beats in total produces a status low pulse of exactly ERR_PULSE (default 4) cycles. Status then returns high, and load-done stays low.
- R7: If `load_err_i` is high during a load, the same ERR_PULSE-cycle low pulse is produced.
- R8: After an error pulse, status stays high and ready stays low until the request pin goes low. Status then falls, and the block is in idle and accepts a new rising request.
- R9: In user mode, a low-to-high request clears load-done and init-done at once. Status then stays high for exactly CLEAN_CYC (default 64) cycles and falls, and the block returns to idle.
- R10: A rising edge on `jtag_start_i` after power-on starts a load from any state, including user mode, where it clears load-done. A complete JTAG load ends in user mode.
- R11: While a JTAG-started load is in progress, a falling edge on the request pin aborts it: ready, status and load-done go low.
- R12: With mode-select equal to 3'b111 at power-on, a rising request is ignored and status stays low. A JTAG start still loads the device up to user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| msel_i | input | MSEL_W | Mode-select pins, sampled once after reset |
| cfg_req_n_i | input | 1 | Active-low configuration request from the host |
| jtag_start_i | input | 1 | JTAG load start strobe, rising edge active |
| load_err_i | input | 1 | Load error flag, level, acted on only while loading |
| s_valid_i | input | 1 | Stream beat valid |
| s_last_i | input | 1 | Marks the final beat of the bitstream |
| s_ready_o | output | 1 | Stream ready, high only while loading |
| status_n_o | output | 1 | Active-low status line |
| load_done_o | output | 1 | Bitstream fully received |
| init_done_o | output | 1 | Device in user mode |

## Verification
Loads are driven with random beat counts and random valid gaps. Each one ends in one of three ways: with the last marker at or beyond the expected count, with the marker too early, or with the error input raised part-way through. Comparing these shows whether completion is decided by count and marker together and not by either alone. Directed cases cover several situations. Beats are offered while ready is low. The request is held constantly high. A JTAG start is issued from user mode. A JTAG load is aborted by a falling request. A second power-up is run in JTAG mode. Together these separate true edge detection from level sensing, and they also separate the JTAG path from the host-request path.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_IDLE  = 3'd1,
    ST_LOAD  = 3'd2,
    ST_ERRP  = 3'd3,
    ST_ERRH  = 3'd4,
    ST_INIT  = 3'd5,
    ST_USER  = 3'd6,
    ST_CLEAN = 3'd7
  } seq_state_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/cfg_beat_cnt.sv
module cfg_beat_cnt #(
  parameter int unsigned EXP_WORDS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic beat_i,
  input  logic last_i,
  output logic fin_ok_o,
  output logic fin_short_o
);
  localparam int unsigned CW = $clog2(EXP_WORDS + 1);
  localparam logic [CW:0] EXP_V = (CW+1)'(EXP_WORDS);

  logic [CW-1:0] cnt;
  logic [CW:0]   nxt;

  assign nxt         = {1'b0, cnt} + 1'b1;
  assign fin_ok_o    = beat_i && last_i && (nxt >= EXP_V);
  assign fin_short_o = beat_i && last_i && (nxt <  EXP_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (clr_i)                            cnt <= '0;
    else if (beat_i && ({1'b0, cnt} != EXP_V)) cnt <= cnt + 1'b1;
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} <= EXP_V));
endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
  import cfg_seq_pkg::*;
#(
  parameter int unsigned MSEL_W     = 3,
  parameter logic [MSEL_W-1:0] JTAG_SEL = '1,
  parameter int unsigned ERR_PULSE  = 4,
  parameter int unsigned INIT_CYC   = 8,
  parameter int unsigned CLEAN_CYC  = 64,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MSEL_W-1:0] msel_s_i,
  input  logic              req_n_s_i,
  input  logic              jst_s_i,
  input  logic              err_s_i,
  input  logic              fin_ok_i,
  input  logic              fin_short_i,
  output logic              cnt_clr_o,
  output logic              s_ready_o,
  output logic              status_n_o,
  output logic              load_done_o,
  output logic              init_done_o
);
  localparam int unsigned M1 = (ERR_PULSE > INIT_CYC) ? ERR_PULSE : INIT_CYC;
  localparam int unsigned M2 = (M1 > CLEAN_CYC) ? M1 : CLEAN_CYC;
  localparam int unsigned CNT_MAX = (M2 > SYNC_DEPTH) ? M2 : SYNC_DEPTH;
  localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ERR_LD   = CNT_W'(ERR_PULSE - 1);
  localparam logic [CNT_W-1:0] INIT_LD  = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] CLEAN_LD = CNT_W'(CLEAN_CYC - 1);
  localparam logic [CNT_W-1:0] POR_LD   = CNT_W'(SYNC_DEPTH);

  seq_state_t       state, nstate;
  logic [CNT_W-1:0] cnt, ncnt;
  logic             jtag_mode, n_mode;
  logic             por_seen, n_por;
  logic             jtag_act, n_jact;
  logic             req_q, jst_q;
  logic             req_rise, req_fall, jst_rise;
  seq_state_t       home;

  assign req_rise = req_n_s_i && !req_q;
  assign req_fall = !req_n_s_i && req_q;
  assign jst_rise = jst_s_i && !jst_q;
  assign home     = jtag_mode ? ST_START : ST_IDLE;

  always_comb begin
    nstate    = state;
    ncnt      = (cnt != '0) ? cnt - 1'b1 : '0;
    n_mode    = jtag_mode;
    n_por     = por_seen;
    n_jact    = jtag_act;
    cnt_clr_o = 1'b0;
    if (por_seen && jst_rise) begin
      nstate    = ST_LOAD;
      n_jact    = 1'b1;
      cnt_clr_o = 1'b1;
    end else begin
      case (state)
        ST_START: begin
          if (!por_seen && cnt == '0) begin
            n_por  = 1'b1;
            n_mode = (msel_s_i == JTAG_SEL);
            if (msel_s_i != JTAG_SEL) nstate = ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (req_rise) begin
            nstate = ST_LOAD;
            n_jact = 1'b0;
          end
        end
        ST_LOAD: begin
          if (jtag_act && req_fall) begin
            nstate = home;
            n_jact = 1'b0;
          end else if (err_s_i || fin_short_i) begin
            nstate = ST_ERRP;
            ncnt   = ERR_LD;
          end else if (fin_ok_i) begin
            nstate = ST_INIT;
            ncnt   = INIT_LD;
          end
        end
        ST_ERRP:  if (cnt == '0) nstate = ST_ERRH;
        ST_ERRH:  if (!req_n_s_i) nstate = home;
        ST_INIT:  if (cnt == '0) nstate = ST_USER;
        ST_USER: begin
          if (req_rise) begin
            nstate = ST_CLEAN;
            ncnt   = CLEAN_LD;
          end
        end
        ST_CLEAN: if (cnt == '0) nstate = home;
        default:  nstate = home;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_START;
      cnt       <= POR_LD;
      jtag_mode <= 1'b0;
      por_seen  <= 1'b0;
      jtag_act  <= 1'b0;
      req_q     <= 1'b0;
      jst_q     <= 1'b0;
    end else begin
      state     <= nstate;
      cnt       <= ncnt;
      jtag_mode <= n_mode;
      por_seen  <= n_por;
      jtag_act  <= n_jact;
      req_q     <= req_n_s_i;
      jst_q     <= jst_s_i;
    end
  end

  assign s_ready_o   = (state == ST_LOAD);
  assign status_n_o  = (state == ST_LOAD) || (state == ST_ERRH) || (state == ST_INIT) ||
                       (state == ST_USER) || (state == ST_CLEAN);
  assign load_done_o = (state == ST_INIT) || (state == ST_USER);
  assign init_done_o = (state == ST_USER);

  // R5
  init_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> $past(load_done_o));
  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done_o) |-> $past(fin_ok_i));
  // R6
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERRP && cnt == '0 && !(por_seen && jst_rise)) |=> status_n_o);
  // R9
  clean_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_USER && req_rise && !jst_rise) |=> (!load_done_o && !init_done_o && status_n_o));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !req_rise && !(por_seen && jst_rise)) |=> !status_n_o);
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top #(
  parameter int unsigned MSEL_W     = 3,
  parameter logic [MSEL_W-1:0] JTAG_SEL = '1,
  parameter int unsigned EXP_WORDS  = 8,
  parameter int unsigned ERR_PULSE  = 4,
  parameter int unsigned INIT_CYC   = 8,
  parameter int unsigned CLEAN_CYC  = 64,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MSEL_W-1:0] msel_i,
  input  logic              cfg_req_n_i,
  input  logic              jtag_start_i,
  input  logic              load_err_i,
  input  logic              s_valid_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  output logic              status_n_o,
  output logic              load_done_o,
  output logic              init_done_o
);
  localparam int unsigned PIN_W = MSEL_W + 3;

  logic [PIN_W-1:0]  pins_raw, pins_s;
  logic [MSEL_W-1:0] msel_s;
  logic              req_n_s, jst_s, err_s;
  logic              beat, fin_ok, fin_short, cnt_clr, rdy;

  assign pins_raw = {msel_i, cfg_req_n_i, jtag_start_i, load_err_i};
  assign {msel_s, req_n_s, jst_s, err_s} = pins_s;

  cfg_sync #(.W(PIN_W), .DEPTH(SYNC_DEPTH), .RST_VAL('0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s)
  );

  assign beat = s_valid_i && rdy;

  cfg_beat_cnt #(.EXP_WORDS(EXP_WORDS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr || !rdy), .beat_i(beat),
    .last_i(s_last_i), .fin_ok_o(fin_ok), .fin_short_o(fin_short)
  );

  cfg_fsm #(
    .MSEL_W(MSEL_W), .JTAG_SEL(JTAG_SEL), .ERR_PULSE(ERR_PULSE),
    .INIT_CYC(INIT_CYC), .CLEAN_CYC(CLEAN_CYC), .SYNC_DEPTH(SYNC_DEPTH)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .msel_s_i(msel_s), .req_n_s_i(req_n_s),
    .jst_s_i(jst_s), .err_s_i(err_s), .fin_ok_i(fin_ok), .fin_short_i(fin_short),
    .cnt_clr_o(cnt_clr), .s_ready_o(rdy), .status_n_o(status_n_o),
    .load_done_o(load_done_o), .init_done_o(init_done_o)
  );

  assign s_ready_o = rdy;

  // R3
  ready_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> status_n_o);
  // R5
  init_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |-> load_done_o);
endmodule

// File: tb/tb_cfg_seq_top.sv
module tb_cfg_seq_top;
  localparam int EXP = 8;
  localparam int ERRW = 4;
  localparam int INITW = 8;
  localparam int CLEANW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] msel = 3'd0;
  logic req_n = 1'b0, jst = 1'b0, err = 1'b0, vld = 1'b0, lst = 1'b0;
  logic rdy, st_n, ld, id;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  cfg_seq_top #(.MSEL_W(3), .JTAG_SEL(3'b111), .EXP_WORDS(EXP), .ERR_PULSE(ERRW),
                .INIT_CYC(INITW), .CLEAN_CYC(CLEANW), .SYNC_DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .msel_i(msel), .cfg_req_n_i(req_n),
    .jtag_start_i(jst), .load_err_i(err), .s_valid_i(vld), .s_last_i(lst),
    .s_ready_o(rdy), .status_n_o(st_n), .load_done_o(ld), .init_done_o(id)
  );

  function automatic bit expect_ok(int n, bit with_last, bit with_err);
    return with_last && !with_err && (n >= EXP);
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_jst();
    jst = 1'b1; tick(3); jst = 1'b0;
  endtask

  task automatic start_load(string tag);
    int k = 0;
    req_n = 1'b0; tick(3); req_n = 1'b1;
    while (!rdy && k < 10) begin tick(1); k++; end
    chk({tag, " load started"}, int'(rdy && st_n), 1);
  endtask

  task automatic send(int n, bit with_last);
    for (int i = 0; i < n; i++) begin
      int k = 0;
      vld = 1'b0;
      tick($urandom_range(0, 2));
      vld = 1'b1;
      lst = with_last && (i == n - 1);
      while (!rdy && k < 50) begin tick(1); k++; end
      tick(1);
    end
    vld = 1'b0; lst = 1'b0;
  endtask

  task automatic expect_pulse(string tag);
    int k = 0, w = 0;
    while (st_n && k < 10) begin tick(1); k++; end
    while (!st_n && w < 40) begin tick(1); w++; end
    chk({tag, " pulse width"}, w, ERRW);
    chk({tag, " no load_done"}, int'(ld), 0);
  endtask

  task automatic recover(string tag);
    int k = 0;
    req_n = 1'b0;
    while (st_n && k < 10) begin tick(1); k++; end
    chk({tag, " status low after request low"}, int'(st_n), 0);
  endtask

  task automatic expect_done(string tag);
    int k = 0, w = 0;
    while (!ld && k < 10) begin tick(1); k++; end
    chk({tag, " load_done"}, int'(ld), 1);
    while (ld && !id && w < 60) begin tick(1); w++; end
    chk({tag, " init delay"}, w, INITW);
    chk({tag, " init_done"}, int'(id), 1);
  endtask

  task automatic do_clean(string tag);
    int k = 0, w = 0;
    req_n = 1'b0; tick(4); req_n = 1'b1;
    while (ld && k < 10) begin tick(1); k++; end
    chk({tag, " init_done cleared"}, int'(id), 0);
    while (st_n && w < 300) begin tick(1); w++; end
    chk({tag, " clean length"}, w, CLEANW);
    chk({tag, " load_done low after clean"}, int'(ld), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    tick(4);
    // R1 reset state
    chk("R1 status in reset", int'(st_n), 0);
    chk("R1 load_done in reset", int'(ld), 0);
    chk("R1 init_done in reset", int'(id), 0);
    chk("R1 ready in reset", int'(rdy), 0);
    rst_n = 1'b1;
    tick(8);
    chk("R1 status after reset", int'(st_n), 0);
    chk("R2 no request keeps idle", int'(rdy), 0);

    // R3 beats offered while not ready are not counted
    vld = 1'b1; lst = 1'b1; tick(6);
    chk("R3 ready low in idle", int'(rdy), 0);
    vld = 1'b0; lst = 1'b0;

    // R2, R4, R5 directed full load
    start_load("R2");
    send(EXP - 1, 1'b0);
    tick(2);
    chk("R4 no load_done before last", int'(ld), 0);
    send(1, 1'b1);
    expect_done("R4 R5 R3");

    // R9 clean from user mode
    do_clean("R9");

    // R2 request held high stays idle
    tick(20);
    chk("R2 held-high request ignored", int'(st_n), 0);
    chk("R2 held-high ready", int'(rdy), 0);

    // R6 short bitstream, then R8 hold and recover
    start_load("R6");
    send(5, 1'b1);
    expect_pulse("R6");
    tick(10);
    chk("R8 status held high", int'(st_n), 1);
    chk("R8 ready low after error", int'(rdy), 0);
    recover("R8");
    start_load("R8 idle again");

    // R7 error input during load
    send(3, 1'b0);
    err = 1'b1;
    expect_pulse("R7");
    err = 1'b0;
    recover("R7");

    // random mix
    for (int it = 0; it < 20; it++) begin
      int kind = $urandom_range(0, 2);
      int n;
      bit wl, we;
      if (kind == 0) begin n = EXP + $urandom_range(0, 3); wl = 1'b1; we = 1'b0; end
      else if (kind == 1) begin n = $urandom_range(1, EXP - 1); wl = 1'b1; we = 1'b0; end
      else begin n = $urandom_range(1, EXP - 1); wl = 1'b0; we = 1'b1; end
      start_load("R2 random");
      send(n, wl);
      if (we) err = 1'b1;
      if (expect_ok(n, wl, we)) begin
        expect_done("R4 random");
        do_clean("R9 random");
      end else begin
        expect_pulse(we ? "R7 random" : "R6 random");
        err = 1'b0;
        recover("R8 random");
      end
    end

    // R10 JTAG start from user mode
    start_load("R10 setup");
    send(EXP, 1'b1);
    expect_done("R10 setup");
    pulse_jst();
    begin
      int k = 0;
      while (!rdy && k < 10) begin tick(1); k++; end
    end
    chk("R10 jtag load started", int'(rdy), 1);
    chk("R10 load_done cleared", int'(ld), 0);
    send(EXP, 1'b1);
    expect_done("R10 jtag");

    // R11 abort JTAG load on request falling edge
    pulse_jst();
    tick(3);
    chk("R11 jtag load active", int'(rdy), 1);
    send(3, 1'b0);
    req_n = 1'b0;
    begin
      int k = 0;
      while (rdy && k < 10) begin tick(1); k++; end
    end
    chk("R11 ready after abort", int'(rdy), 0);
    chk("R11 status after abort", int'(st_n), 0);
    chk("R11 load_done after abort", int'(ld), 0);
    start_load("R11 idle after abort");

    // R12 power-up in JTAG mode
    rst_n = 1'b0; req_n = 1'b0; msel = 3'b111; tick(4);
    rst_n = 1'b1; tick(10);
    req_n = 1'b1; tick(10);
    chk("R12 request ignored status", int'(st_n), 0);
    chk("R12 request ignored ready", int'(rdy), 0);
    pulse_jst();
    begin
      int k = 0;
      while (!rdy && k < 10) begin tick(1); k++; end
    end
    chk("R12 jtag load started", int'(rdy), 1);
    send(EXP, 1'b1);
    expect_done("R12 jtag");

    finish_run();
  end
endmodule